// File: doc/BRIEF.md
# Programmable Bus Interrupter

This block raises one interrupt request line out of seven on a backplane bus and then serves the handler's acknowledge cycle. A 16-bit setup word picks the request source, the release mode, the interrupt level and the 8-bit status vector. Three sources are available: a rising edge on an external input, a software write, or an internal periodic tick. The tick runs every `TICK_DIV` clocks, which is 1 kHz at the default clock. While a request is pending, further triggers are ignored.

When the handler runs an acknowledge cycle, the block checks three things: AS, IACK and IACKIN must all be asserted, a request must be pending, and the three acknowledge address lines must carry the programmed level. If all three hold, the block drives the vector onto the low data byte and asserts DTACK a fixed number of clocks later. It releases both drives once AS is released. If the acknowledge is not for this block, it passes the daisy-chain grant on through IACKOUT.

The request is cleared in one of two ways, chosen by the release mode. In register-release mode a write to the trigger register clears it. In acknowledge-release mode the matching acknowledge cycle clears it. All bus inputs are taken as synchronous to `clk` and pass through one sampling register.

Top module: `bus_interrupter`

## Requirements
- R1: After reset, `irq_drive` is 0, `data_oe` and `dtack_drive` are 0, `data_out` is 0 and `iackout_n` is 1.
- R2: The setup word is split into fields as follows:
  - bits 15:14 select the source: 0 = off, 1 = external, 2 = software, 3 = tick.
  - bit 11 selects the release mode: 0 = register, 1 = acknowledge.
  - bits 10:8 hold the level.
  - bits 7:0 hold the vector.
  - bits 13:12 are unused.
  With source 0 selected, no trigger of any kind raises a request.
- R3: With source 1, a rising edge on `ext_in` raises a request at the next clock edge. Level L (1 to 7) drives `irq_drive` bit L-1 alone. Level 0 never raises a request. A trigger from a source that is not selected has no effect.
- R4: With source 2, a write to the trigger register with bit 0 set raises a request at that clock edge.
- R5: With source 3, requests are raised every `TICK_DIV` clocks; two successive raises are exactly `TICK_DIV` clocks apart.
- R6: While a request is pending, further triggers are ignored. Once that request is cleared, no second request is left queued.
- R7: In register-release mode, a trigger-register write with bit 1 set clears the request at that edge. In acknowledge-release mode, that bit has no effect.
- R8: The acknowledge is accepted when AS, IACK and IACKIN are all low, a request is pending and `bus_addr` equals the level. Two edges after that, `data_oe` is 1 and `data_out` holds the vector. `dtack_drive` rises `DTACK_DLY` edges after `data_oe` rises.
- R9: In acknowledge-release mode, `irq_drive` clears at the edge where `data_oe` rises. In register-release mode, `irq_drive` stays driven through the acknowledge.
- R10: Two edges after AS is released, `data_oe` and `dtack_drive` are both 0. One edge after the release they are still driven.
- R11: An acknowledge with a different level, or with no request pending, drives `iackout_n` low two edges after the cycle starts. `data_oe` stays 0. `iackout_n` returns high two edges after IACKIN is released.
- R12: A clear and a trigger arriving in the same cycle leave no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_we | input | 1 | Setup register write strobe |
| setup_wdata | input | 16 | Setup word |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 2 | Bit 0 raises a software request; bit 1 is the release toggle |
| ext_in | input | 1 | External trigger input |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_iack_n | input | 1 | Interrupt acknowledge, active low |
| bus_iackin_n | input | 1 | Daisy-chain acknowledge input, active low |
| bus_addr | input | 3 | Acknowledged level, from address lines 1 to 3 |
| irq_drive | output | 7 | Bit L-1 high means the request line of level L is pulled |
| data_oe | output | 1 | Data byte drive enable |
| data_out | output | 8 | Status vector driven onto data lines 0 to 7 |
| dtack_drive | output | 1 | DTACK drive enable |
| iackout_n | output | 1 | Daisy-chain acknowledge output, active low |

## Verification
The two functions that can fall in the same clock cycle are releasing a request and raising a new one. The bench provokes this in two ways. First, it writes both trigger-register bits in a single write while a request is pending. Second, it raises an external edge in the very cycle of a release write. It judges the outcome at `irq_drive` one edge later, where no line may be driven. It also checks that a trigger arriving during a pending request leaves nothing queued after the release.

// File: rtl/bi_pkg.sv
package bi_pkg;
  localparam int LVL_W   = 3;
  localparam int VEC_W   = 8;
  localparam int LINES   = (1 << LVL_W) - 1;
  localparam int SETUP_W = 16;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_TICK = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    AK_IDLE  = 2'd0,
    AK_DRIVE = 2'd1,
    AK_PASS  = 2'd2
  } ak_state_e;
endpackage

// File: rtl/bi_tick.sv
module bi_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == CW'(DIV - 1));
      cnt_q  <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: the tick never fires in two adjacent cycles
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/bi_request.sv
module bi_request
  import bi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  src_e             src_q,
  input  logic             rel_ack_q,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [LVL_W-1:0] lvl_n,
  input  logic             ext_rise,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic             tick,
  input  logic             ack_hit,
  output logic             pending_o,
  output logic [LINES-1:0] irq_drive_o
);
  logic             trig;
  logic             clr;
  logic             pend_n;
  logic [LINES-1:0] drv_n;

  always_comb begin
    unique case (src_q)
      SRC_EXT:  trig = ext_rise;
      SRC_SW:   trig = sw_set;
      SRC_TICK: trig = tick;
      default:  trig = 1'b0;
    endcase
  end

  // the clear wins over a trigger of the same cycle
  assign clr = rel_ack_q ? ack_hit : sw_clr;

  always_comb begin
    if (clr)
      pend_n = 1'b0;
    else if (trig && !pending_o && (lvl_q != '0))
      pend_n = 1'b1;
    else
      pend_n = pending_o;
  end

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    assign drv_n[gi] = pend_n && (lvl_n == LVL_W'(gi + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o   <= 1'b0;
      irq_drive_o <= '0;
    end else begin
      pending_o   <= pend_n;
      irq_drive_o <= drv_n;
    end
  end

  p_line_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_drive_o));
  p_level_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0) |-> (irq_drive_o == '0));
  p_hold_pending_r6: assert property (@(posedge clk) disable iff (rst)
    (pending_o && !clr) |=> pending_o);
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pending_o);
endmodule

// File: rtl/bi_ack.sv
module bi_ack
  import bi_pkg::*;
#(
  parameter int DTACK_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_n,
  input  logic             iack_n,
  input  logic             iackin_n,
  input  logic [LVL_W-1:0] addr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VEC_W-1:0] vec,
  input  logic             pending,
  output logic             ack_hit,
  output logic             data_oe,
  output logic [VEC_W-1:0] data_o,
  output logic             dtack_o,
  output logic             iackout_n
);
  localparam int CW = $clog2(DTACK_DLY + 1);

  logic             s_as, s_iack, s_iackin;
  logic [LVL_W-1:0] s_addr;
  logic             cyc_on;
  ak_state_e        state_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_as     <= 1'b0;
      s_iack   <= 1'b0;
      s_iackin <= 1'b0;
      s_addr   <= '0;
    end else begin
      s_as     <= !as_n;
      s_iack   <= !iack_n;
      s_iackin <= !iackin_n;
      s_addr   <= addr;
    end
  end

  assign cyc_on  = s_as && s_iack && s_iackin;
  assign ack_hit = (state_q == AK_IDLE) && cyc_on && pending &&
                   (lvl != '0) && (s_addr == lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= AK_IDLE;
      cnt_q     <= '0;
      data_oe   <= 1'b0;
      data_o    <= '0;
      dtack_o   <= 1'b0;
      iackout_n <= 1'b1;
    end else begin
      unique case (state_q)
        AK_IDLE: begin
          if (ack_hit) begin
            state_q <= AK_DRIVE;
            data_oe <= 1'b1;
            data_o  <= vec;
            cnt_q   <= '0;
          end else if (cyc_on) begin
            state_q   <= AK_PASS;
            iackout_n <= 1'b0;
          end
        end
        AK_DRIVE: begin
          if (!s_as) begin
            state_q <= AK_IDLE;
            data_oe <= 1'b0;
            data_o  <= '0;
            dtack_o <= 1'b0;
          end else if (cnt_q == CW'(DTACK_DLY - 1)) begin
            dtack_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        AK_PASS: begin
          if (!s_iackin || !s_as) begin
            state_q   <= AK_IDLE;
            iackout_n <= 1'b1;
          end
        end
        default: state_q <= AK_IDLE;
      endcase
    end
  end

  p_dtack_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
    dtack_o |-> data_oe);
  p_vector_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe)) |-> $stable(data_o));
  p_release_on_as_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == AK_DRIVE && !s_as) |=> (!data_oe && !dtack_o));
  p_pass_excludes_drive_r11: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> iackout_n);
endmodule

// File: rtl/bus_interrupter.sv
module bus_interrupter
  import bi_pkg::*;
#(
  parameter int TICK_DIV  = 125000,
  parameter int DTACK_DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         setup_we,
  input  logic [15:0]  setup_wdata,
  input  logic         trig_we,
  input  logic [1:0]   trig_wdata,
  input  logic         ext_in,
  input  logic         bus_as_n,
  input  logic         bus_iack_n,
  input  logic         bus_iackin_n,
  input  logic [2:0]   bus_addr,
  output logic [6:0]   irq_drive,
  output logic         data_oe,
  output logic [7:0]   data_out,
  output logic         dtack_drive,
  output logic         iackout_n
);
  src_e             src_q;
  logic             rel_q;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic [VEC_W-1:0] vec_q;
  logic             ext_q;
  logic             tick;
  logic             pending;
  logic             ack_hit;
  logic             unused_tmo;

  assign unused_tmo = ^setup_wdata[13:12];
  assign lvl_n      = setup_we ? setup_wdata[10:8] : lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_OFF;
      rel_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_in;
      if (setup_we) begin
        src_q <= src_e'(setup_wdata[15:14]);
        rel_q <= setup_wdata[11];
        lvl_q <= setup_wdata[10:8];
        vec_q <= setup_wdata[7:0];
      end
    end
  end

  bi_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  bi_request u_req (
    .clk         (clk),
    .rst         (rst),
    .src_q       (src_q),
    .rel_ack_q   (rel_q),
    .lvl_q       (lvl_q),
    .lvl_n       (lvl_n),
    .ext_rise    (ext_in && !ext_q),
    .sw_set      (trig_we && trig_wdata[0]),
    .sw_clr      (trig_we && trig_wdata[1]),
    .tick        (tick),
    .ack_hit     (ack_hit),
    .pending_o   (pending),
    .irq_drive_o (irq_drive)
  );

  bi_ack #(.DTACK_DLY(DTACK_DLY)) u_ack (
    .clk       (clk),
    .rst       (rst),
    .as_n      (bus_as_n),
    .iack_n    (bus_iack_n),
    .iackin_n  (bus_iackin_n),
    .addr      (bus_addr),
    .lvl       (lvl_q),
    .vec       (vec_q),
    .pending   (pending),
    .ack_hit   (ack_hit),
    .data_oe   (data_oe),
    .data_o    (data_out),
    .dtack_o   (dtack_drive),
    .iackout_n (iackout_n)
  );

  p_ack_release_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && rel_q) |=> (irq_drive == '0));
endmodule

// File: tb/bus_interrupter_test.sv
module bus_interrupter_test;
  localparam int TDIV = 40;
  localparam int DLY  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_we = 1'b0;
  logic [15:0] setup_wdata = '0;
  logic        trig_we = 1'b0;
  logic [1:0]  trig_wdata = '0;
  logic        ext_in = 1'b0;
  logic        as_n = 1'b1, iack_n = 1'b1, iackin_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [6:0]  irq_drive;
  logic        data_oe, dtack_drive, iackout_n;
  logic [7:0]  data_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_interrupter #(.TICK_DIV(TDIV), .DTACK_DLY(DLY)) uut (
    .clk(clk), .rst(rst), .setup_we(setup_we), .setup_wdata(setup_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .ext_in(ext_in),
    .bus_as_n(as_n), .bus_iack_n(iack_n), .bus_iackin_n(iackin_n),
    .bus_addr(addr), .irq_drive(irq_drive), .data_oe(data_oe),
    .data_out(data_out), .dtack_drive(dtack_drive), .iackout_n(iackout_n)
  );

  // table row: setup word, action (0 ext edge, 1 software write), expected lines
  localparam logic [24:0] TBL [9] = '{
    {16'h435A, 2'd0, 7'b0000100},
    {16'h47C3, 2'd0, 7'b1000000},
    {16'h81A5, 2'd1, 7'b0000001},
    {16'h8511, 2'd0, 7'b0000000},
    {16'h4222, 2'd1, 7'b0000000},
    {16'h0433, 2'd0, 7'b0000000},
    {16'h0433, 2'd1, 7'b0000000},
    {16'h8077, 2'd1, 7'b0000000},
    {16'h8680, 2'd1, 7'b0100000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_setup(input logic [15:0] w);
    setup_we = 1'b1; setup_wdata = w; cyc(1); setup_we = 1'b0;
  endtask

  task automatic wr_trig(input logic [1:0] w);
    trig_we = 1'b1; trig_wdata = w; cyc(1); trig_we = 1'b0; trig_wdata = '0;
  endtask

  task automatic ext_edge();
    ext_in = 1'b1; cyc(1); ext_in = 1'b0;
  endtask

  task automatic ack_start(input logic [2:0] a);
    as_n = 1'b0; iack_n = 1'b0; iackin_n = 1'b0; addr = a;
  endtask

  task automatic ack_end();
    as_n = 1'b1; iack_n = 1'b1; iackin_n = 1'b1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] sw;
    logic [1:0]  act;
    logic [6:0]  exp;
    cyc(3);
    // R1 reset state
    chk(irq_drive == 0 && data_oe == 0 && dtack_drive == 0 && data_out == 0 && iackout_n == 1,
        "R1 reset", {irq_drive, data_oe, dtack_drive, data_out, iackout_n},
        {7'd0, 1'b0, 1'b0, 8'd0, 1'b1});
    rst = 1'b0;
    cyc(1);

    // table walk: R2 source off, R3 ext/levels/wrong source, R4 software
    for (int i = 0; i < 9; i++) begin
      sw = TBL[i][24:9]; act = TBL[i][8:7]; exp = TBL[i][6:0];
      wr_setup(sw);
      if (act == 2'd0) ext_edge(); else wr_trig(2'b01);
      chk(irq_drive == exp, "R2 R3 R4 table", irq_drive, exp);
      cyc(1);
      wr_trig(2'b10);
      chk(irq_drive == 0, "R7 register release", irq_drive, 0);
    end

    // R6: extra triggers while pending leave nothing queued
    wr_setup(16'h435A);
    ext_edge(); cyc(1); ext_edge(); cyc(1); ext_edge();
    chk(irq_drive == 7'b0000100, "R6 pending held", irq_drive, 7'b0000100);
    wr_trig(2'b10); cyc(2);
    chk(irq_drive == 0, "R6 nothing queued", irq_drive, 0);

    // R12: release and trigger in one write
    wr_setup(16'h839C);
    wr_trig(2'b01);
    wr_trig(2'b11);
    chk(irq_drive == 0, "R12 clear beats set (write 3)", irq_drive, 0);
    // R12: external edge in the cycle of a release write
    wr_setup(16'h435A);
    ext_edge(); cyc(1);
    ext_in = 1'b1; trig_we = 1'b1; trig_wdata = 2'b10; cyc(1);
    trig_we = 1'b0; trig_wdata = '0; ext_in = 1'b0;
    chk(irq_drive == 0, "R12 clear beats ext edge", irq_drive, 0);

    // acknowledge-release mode: R7 toggle ignored, R8, R9, R10
    wr_setup(16'h8B9C);
    wr_trig(2'b01);
    chk(irq_drive == 7'b0000100, "R4 software set", irq_drive, 7'b0000100);
    wr_trig(2'b10); cyc(1);
    chk(irq_drive == 7'b0000100, "R7 toggle ignored in ack mode", irq_drive, 7'b0000100);
    ack_start(3'd3); cyc(1);
    chk(data_oe == 0, "R8 not yet driven", data_oe, 0);
    cyc(1);
    chk(data_oe == 1 && data_out == 8'h9C, "R8 vector", {data_oe, data_out}, {1'b1, 8'h9C});
    chk(irq_drive == 0, "R9 ack release", irq_drive, 0);
    chk(iackout_n == 1, "R11 no pass on match", iackout_n, 1);
    cyc(1);
    chk(dtack_drive == 0, "R8 dtack early", dtack_drive, 0);
    cyc(1);
    chk(dtack_drive == 1, "R8 dtack delay", dtack_drive, 1);
    ack_end(); cyc(1);
    chk(data_oe == 1 && dtack_drive == 1, "R10 still driven", {data_oe, dtack_drive}, 2'b11);
    cyc(1);
    chk(data_oe == 0 && dtack_drive == 0 && data_out == 0, "R10 released",
        {data_oe, dtack_drive, data_out}, 10'd0);

    // register-release mode keeps the line through the acknowledge (R9)
    wr_setup(16'h839C);
    wr_trig(2'b01);
    ack_start(3'd3); cyc(2);
    chk(data_oe == 1 && data_out == 8'h9C, "R8 vector mode 0", {data_oe, data_out}, {1'b1, 8'h9C});
    chk(irq_drive == 7'b0000100, "R9 held in register mode", irq_drive, 7'b0000100);
    ack_end(); cyc(3);

    // R11 pass-through: wrong level, pending request stays
    ack_start(3'd5); cyc(2);
    chk(iackout_n == 0 && data_oe == 0, "R11 pass wrong level", {iackout_n, data_oe}, 2'b00);
    chk(irq_drive == 7'b0000100, "R11 request kept", irq_drive, 7'b0000100);
    ack_end(); cyc(1);
    chk(iackout_n == 0, "R11 pass held", iackout_n, 0);
    cyc(1);
    chk(iackout_n == 1, "R11 pass ends", iackout_n, 1);
    wr_trig(2'b10); cyc(1);
    // R11 pass-through: matching level but nothing pending
    ack_start(3'd3); cyc(2);
    chk(iackout_n == 0 && data_oe == 0, "R11 pass no request", {iackout_n, data_oe}, 2'b00);
    ack_end(); cyc(3);

    // R5 periodic tick
    wr_setup(16'hC500);
    n = 0;
    while (irq_drive == 0 && n < 200) begin cyc(1); n++; end
    chk(irq_drive == 7'b0010000, "R5 tick request", irq_drive, 7'b0010000);
    wr_trig(2'b10);
    n = 1;
    while (irq_drive == 0 && n < 200) begin cyc(1); n++; end
    chk(n == TDIV, "R5 tick period", n, TDIV);

    done = 1;
    summary();
    $finish;
  end
endmodule